// File: doc/BRIEF.md
# Multiword DMA Burst Sequencer

This block runs the host side of multiword DMA bursts on a parallel disk-drive bus. The device raises its request line and the sequencer answers. It first runs a setup phase, then raises the acknowledge line. After that it repeats word cycles. In each word cycle the read or write strobe is held active for a programmed time and then negated for a programmed recovery time. A programmed minimum cycle period also applies to each word cycle. Read words are captured from the bus when the strobe ends and are pushed into a receive FIFO. Write words are taken from a show-ahead transmit FIFO when the strobe starts.

When the request is seen low at a word-cycle boundary, a closing phase runs. At its end the acknowledge and the DMA-busy flag drop together. While the busy flag is high, the programmed-I/O path must keep its chip selects and address negated.

Every phase length comes from an 8-bit count supplied by software. A count of zero lasts one clock. The transfer direction is sampled when the burst begins.

Top module: `mdma_seq`

## Requirements
- R1: After reset, host_ack, rd_strobe, wr_strobe, bus_oe, tx_pop, rx_push and dma_busy are all 0.
- R2: When dev_req is sampled 1 in idle, dma_busy rises at that edge. host_ack rises max(cfg_setup,1) clocks later, together with the strobe when the FIFO condition allows it.
- R3: In a read burst (cfg_write=0 at start), rd_strobe stays high for max(cfg_act,1) clocks. At the edge that ends it, bus_din is captured into rx_data and rx_push pulses for one clock.
- R4: In a write burst (cfg_write=1 at start), tx_pop pulses for one clock in the first strobe clock. bus_dout then holds the head word of the FIFO, and bus_oe is high exactly while wr_strobe is high.
- R5: After the strobe drops, it stays low for at least max(cfg_rec,1) clocks. Strobe rises are spaced max(max(cfg_act,1)+max(cfg_rec,1), max(cfg_cycle,1)) clocks apart while dev_req stays 1.
- R6: If dev_req is 0 at a word-cycle boundary, or at the end of setup, a closing phase of max(cfg_hold_a,cfg_hold_b,1) clocks runs. host_ack and dma_busy then fall at the same edge, and the block returns to idle.
- R7: A strobe never starts while the FIFO cannot take part: the transmit FIFO is empty in a write, or the receive FIFO is full in a read. In that case host_ack stays 1, the strobe stays 0, and no pop or push occurs. The strobe starts at the first edge where the condition has cleared.
- R8: A count of zero in any phase register lasts exactly one clock.
- R9: rd_strobe appears only in read bursts and wr_strobe only in write bursts. A change of cfg_write during a burst has no effect.
- R10: dma_busy is high from burst start to the end of the closing phase. host_ack is never high while dma_busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_write | input | 1 | Direction: 1 write to device, 0 read from device |
| cfg_setup | input | 8 | Setup count before acknowledge |
| cfg_act | input | 8 | Strobe-active count |
| cfg_rec | input | 8 | Strobe-recovery count |
| cfg_cycle | input | 8 | Minimum word-cycle count |
| cfg_hold_a | input | 8 | First closing count |
| cfg_hold_b | input | 8 | Second closing count |
| dev_req | input | 1 | Device DMA request |
| host_ack | output | 1 | Host DMA acknowledge |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| bus_din | input | DW | Data from the device bus |
| bus_dout | output | DW | Data to the device bus |
| bus_oe | output | 1 | Drive enable for bus_dout |
| tx_data | input | DW | Head word of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Transmit FIFO pop |
| rx_full | input | 1 | Receive FIFO full |
| rx_data | output | DW | Word pushed to the receive FIFO |
| rx_push | output | 1 | Receive FIFO push |
| dma_busy | output | 1 | Burst in progress; blocks programmed-I/O bus drive |

## Verification
The bench uses all-zero counts. A design that did not stretch zero to one clock would hang in a phase or skip it. The bench also uses a cycle count shorter than active plus recovery, where a sequencer waiting only on the cycle count would shorten recovery.

It empties the transmit FIFO in the middle of a write burst and fills the receive FIFO in a read burst. A wrong gate would pop an empty FIFO or push into a full one, or would drop the acknowledge.

A one-clock request pulse checks that the closing phase still runs and that the acknowledge never rises. A flip of the direction input during a read burst would, in a faulty design, produce a write strobe.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_GATE,
    ST_ACT,
    ST_REC,
    ST_HOLD,
    ST_TAIL
  } mdma_st_t;
endpackage

// File: rtl/mdma_timer.sv
module mdma_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] cnt;

  // zero is stretched to one clock; count saturates at zero
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (load_val == '0) ? ONE : load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  assign last = (cnt <= ONE);
endmodule

// File: rtl/mdma_dpath.sv
module mdma_dpath #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_word,
  input  logic          end_act,
  input  logic          dir_wr,
  input  logic [DW-1:0] tx_data,
  input  logic [DW-1:0] bus_din,
  output logic          tx_pop,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          rx_push,
  output logic [DW-1:0] rx_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pop   <= 1'b0;
      bus_dout <= '0;
      bus_oe   <= 1'b0;
      rx_push  <= 1'b0;
      rx_data  <= '0;
    end else begin
      tx_pop  <= start_word && dir_wr;
      rx_push <= end_act && !dir_wr;
      if (start_word && dir_wr) begin
        bus_dout <= tx_data;
        bus_oe   <= 1'b1;
      end else if (end_act) begin
        bus_oe <= 1'b0;
      end
      if (end_act && !dir_wr) begin
        rx_data <= bus_din;
      end
    end
  end
endmodule

// File: rtl/mdma_seq.sv
module mdma_seq
  import mdma_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_write,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_act,
  input  logic [CW-1:0] cfg_rec,
  input  logic [CW-1:0] cfg_cycle,
  input  logic [CW-1:0] cfg_hold_a,
  input  logic [CW-1:0] cfg_hold_b,
  input  logic          dev_req,
  output logic          host_ack,
  output logic          rd_strobe,
  output logic          wr_strobe,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_empty,
  output logic          tx_pop,
  input  logic          rx_full,
  output logic [DW-1:0] rx_data,
  output logic          rx_push,
  output logic          dma_busy
);
  mdma_st_t      st;
  logic          dir_q;
  logic          m_last, t_last;
  logic          m_load;
  logic [CW-1:0] m_val;
  logic [CW-1:0] tail_val;
  logic          at_decide, fifo_ok, go, to_tail, stall, end_act;

  assign tail_val = (cfg_hold_a > cfg_hold_b) ? cfg_hold_a : cfg_hold_b;
  assign fifo_ok  = dir_q ? !tx_empty : !rx_full;

  always_comb begin
    at_decide = (st == ST_GATE)
             || (st == ST_SETUP && m_last)
             || (st == ST_REC && m_last && t_last)
             || (st == ST_HOLD && t_last);
    go      = at_decide && dev_req && fifo_ok;
    to_tail = at_decide && !dev_req;
    stall   = at_decide && dev_req && !fifo_ok;
    end_act = (st == ST_ACT) && m_last;
  end

  always_comb begin
    m_load = 1'b0;
    m_val  = '0;
    if (st == ST_IDLE && dev_req) begin
      m_load = 1'b1;
      m_val  = cfg_setup;
    end else if (go) begin
      m_load = 1'b1;
      m_val  = cfg_act;
    end else if (to_tail) begin
      m_load = 1'b1;
      m_val  = tail_val;
    end else if (end_act) begin
      m_load = 1'b1;
      m_val  = cfg_rec;
    end
  end

  mdma_timer #(.CW(CW)) u_phase (
    .clk(clk), .rst(rst), .load(m_load), .load_val(m_val), .last(m_last)
  );

  mdma_timer #(.CW(CW)) u_cycle (
    .clk(clk), .rst(rst), .load(go), .load_val(cfg_cycle), .last(t_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      dir_q     <= 1'b0;
      host_ack  <= 1'b0;
      rd_strobe <= 1'b0;
      wr_strobe <= 1'b0;
      dma_busy  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (dev_req) begin
          st       <= ST_SETUP;
          dma_busy <= 1'b1;
          dir_q    <= cfg_write;
        end
        ST_ACT: if (m_last) begin
          rd_strobe <= 1'b0;
          wr_strobe <= 1'b0;
          st        <= ST_REC;
        end
        ST_REC: if (m_last && !t_last) st <= ST_HOLD;
        ST_TAIL: if (m_last) begin
          st       <= ST_IDLE;
          host_ack <= 1'b0;
          dma_busy <= 1'b0;
        end
        default: ;
      endcase
      if (go) begin
        st        <= ST_ACT;
        host_ack  <= 1'b1;
        rd_strobe <= !dir_q;
        wr_strobe <= dir_q;
      end else if (to_tail) begin
        st <= ST_TAIL;
      end else if (stall) begin
        st       <= ST_GATE;
        host_ack <= 1'b1;
      end
    end
  end

  mdma_dpath #(.DW(DW)) u_dpath (
    .clk(clk), .rst(rst), .start_word(go), .end_act(end_act), .dir_wr(dir_q),
    .tx_data(tx_data), .bus_din(bus_din), .tx_pop(tx_pop), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .rx_push(rx_push), .rx_data(rx_data)
  );
endmodule

// File: rtl/mdma_seq_chk.sv
module mdma_seq_chk (
  input logic clk,
  input logic rst,
  input logic host_ack,
  input logic rd_strobe,
  input logic wr_strobe,
  input logic bus_oe,
  input logic tx_pop,
  input logic tx_empty,
  input logic rx_push,
  input logic rx_full,
  input logic dma_busy
);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe && wr_strobe));
  assert_ack_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> dma_busy);
  assert_strobe_ack_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe || wr_strobe) |-> host_ack);
  assert_pop_at_rise_R4: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> $rose(wr_strobe));
  assert_oe_write_R4: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> wr_strobe);
  assert_push_at_fall_R3: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> $fell(rd_strobe));
  assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_strobe) |-> !$past(tx_empty));
  assert_no_push_full_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_strobe) |-> !$past(rx_full));
  assert_ack_busy_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(host_ack) |-> $fell(dma_busy));
endmodule

bind mdma_seq mdma_seq_chk u_chk (
  .clk(clk), .rst(rst), .host_ack(host_ack), .rd_strobe(rd_strobe),
  .wr_strobe(wr_strobe), .bus_oe(bus_oe), .tx_pop(tx_pop), .tx_empty(tx_empty),
  .rx_push(rx_push), .rx_full(rx_full), .dma_busy(dma_busy)
);

// File: tb/tb_mdma_seq.sv
module tb_mdma_seq;
  localparam int DW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic cfg_write = 1'b0;
  logic [CW-1:0] cfg_setup = '0, cfg_act = '0, cfg_rec = '0, cfg_cycle = '0;
  logic [CW-1:0] cfg_hold_a = '0, cfg_hold_b = '0;
  logic dev_req = 1'b0;
  logic [DW-1:0] din_r = '0, tx_data_r = '0;
  logic tx_empty_r = 1'b1, rx_full_r = 1'b0;
  logic host_ack, rd_strobe, wr_strobe, bus_oe, tx_pop, rx_push, dma_busy;
  logic [DW-1:0] bus_dout, rx_data;

  mdma_seq #(.DW(DW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .cfg_write(cfg_write), .cfg_setup(cfg_setup),
    .cfg_act(cfg_act), .cfg_rec(cfg_rec), .cfg_cycle(cfg_cycle),
    .cfg_hold_a(cfg_hold_a), .cfg_hold_b(cfg_hold_b), .dev_req(dev_req),
    .host_ack(host_ack), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .bus_din(din_r), .bus_dout(bus_dout), .bus_oe(bus_oe), .tx_data(tx_data_r),
    .tx_empty(tx_empty_r), .tx_pop(tx_pop), .rx_full(rx_full_r),
    .rx_data(rx_data), .rx_push(rx_push), .dma_busy(dma_busy)
  );

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  logic [DW-1:0] txq[$];
  logic [DW-1:0] rxq[$];
  int rx_cap = 64;
  bit drain = 1'b0;
  int m_npush = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int one_min(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // behavioural reference: phase name, clocks left in phase, clocks into word
  int ph = 0, left = 0, wc = 0;
  bit mdir = 0;
  logic e_ack = 0, e_rd = 0, e_wr = 0, e_busy = 0, e_pop = 0, e_push = 0, e_oe = 0;
  logic [DW-1:0] e_dout = '0, e_rdata = '0;

  task automatic boundary();
    bit ready;
    ready = mdir ? !tx_empty_r : !rx_full_r;
    if (!dev_req) begin
      ph = 6;
      left = one_min((cfg_hold_a > cfg_hold_b) ? int'(cfg_hold_a) : int'(cfg_hold_b));
    end else if (ready) begin
      ph = 3; left = one_min(int'(cfg_act)); wc = 0; e_ack = 1;
      if (mdir) begin e_wr = 1; e_pop = 1; e_oe = 1; e_dout = tx_data_r; end
      else e_rd = 1;
    end else begin
      ph = 2; e_ack = 1;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; left = 0; wc = 0; mdir = 0;
      e_ack = 0; e_rd = 0; e_wr = 0; e_busy = 0; e_pop = 0; e_push = 0; e_oe = 0;
      e_dout = '0; e_rdata = '0;
    end else begin
      e_pop = 0; e_push = 0;
      case (ph)
        0: if (dev_req) begin
          ph = 1; e_busy = 1; mdir = cfg_write; left = one_min(int'(cfg_setup));
        end
        1: if (left == 1) boundary(); else left--;
        2: boundary();
        3: begin
          wc++;
          if (left == 1) begin
            e_rd = 0; e_wr = 0;
            if (mdir) e_oe = 0;
            else begin e_push = 1; e_rdata = din_r; m_npush++; end
            ph = 4; left = one_min(int'(cfg_rec));
          end else left--;
        end
        4: begin
          wc++;
          if (left == 1) begin
            if (wc >= one_min(int'(cfg_cycle))) boundary(); else ph = 5;
          end else left--;
        end
        5: begin
          wc++;
          if (wc >= one_min(int'(cfg_cycle))) boundary();
        end
        6: if (left == 1) begin ph = 0; e_ack = 0; e_busy = 0; end else left--;
        default: ;
      endcase
    end
  end

  // per-clock comparison, then FIFO models, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R10", "dma_busy", dma_busy, e_busy);
      chk("R6", "host_ack", host_ack, e_ack);
      chk("R9", "rd_strobe", rd_strobe, e_rd);
      chk("R9", "wr_strobe", wr_strobe, e_wr);
      chk("R4", "tx_pop", tx_pop, e_pop);
      chk("R4", "bus_oe", bus_oe, e_oe);
      chk("R3", "rx_push", rx_push, e_push);
      if (e_oe) chk("R4", "bus_dout", bus_dout, e_dout);
      if (e_push) chk("R3", "rx_data", rx_data, e_rdata);
      if (tx_pop && txq.size() > 0) void'(txq.pop_front());
      if (rx_push) rxq.push_back(rx_data);
    end
    if (drain && rxq.size() > 0) void'(rxq.pop_front());
    tx_empty_r = (txq.size() == 0);
    tx_data_r  = (txq.size() == 0) ? '0 : txq[0];
    rx_full_r  = (rxq.size() >= rx_cap);
    din_r      = din_r + 16'h0111;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input bit w, input int s, a, r, c, ha, hb);
    cfg_write = w; cfg_setup = CW'(s); cfg_act = CW'(a); cfg_rec = CW'(r);
    cfg_cycle = CW'(c); cfg_hold_a = CW'(ha); cfg_hold_b = CW'(hb);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300 && dma_busy; i++) @(negedge clk);
    cyc(2);
  endtask

  initial begin
    int k, h, l, cnt, seen;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1", "outputs after reset",
        {25'd0, host_ack, rd_strobe, wr_strobe, bus_oe, tx_pop, rx_push, dma_busy}, 32'd0);

    // read burst: setup 2, active 3, recovery 2, cycle 8
    set_cfg(0, 2, 3, 2, 8, 1, 2);
    dev_req = 1'b1;
    k = 0;
    while (!dma_busy && k < 20) begin @(negedge clk); k++; end
    chk("R2", "clocks to dma_busy", k, 1);
    while (!host_ack && k < 20) begin @(negedge clk); k++; end
    chk("R2", "clocks to host_ack", k, 3);
    chk("R2", "rd_strobe with ack", rd_strobe, 1);
    h = 0; while (rd_strobe && h < 50) begin h++; @(negedge clk); end
    l = 0; while (!rd_strobe && l < 50) begin l++; @(negedge clk); end
    chk("R3", "read strobe width", h, 3);
    chk("R5", "read word period", h + l, 8);
    cyc(30);
    dev_req = 1'b0;
    wait_idle();
    chk("R3", "words received", rxq.size(), m_npush);

    // write burst: cycle shorter than active+recovery, FIFO runs dry
    set_cfg(1, 1, 2, 1, 2, 3, 0);
    txq.push_back(16'hA001); txq.push_back(16'hA002); txq.push_back(16'hA003);
    cyc(1);
    dev_req = 1'b1;
    cyc(4);
    while (!wr_strobe && k < 100) begin @(negedge clk); k++; end
    h = 0; while (wr_strobe && h < 50) begin h++; @(negedge clk); end
    l = 0; while (!wr_strobe && l < 50) begin l++; @(negedge clk); end
    chk("R5", "write period keeps recovery", h + l, 3);
    cyc(25);
    chk("R7", "tx drained", txq.size(), 0);
    chk("R7", "strobe held off on empty", wr_strobe, 0);
    chk("R7", "ack held while empty", host_ack, 1);
    chk("R9", "no rd_strobe in write", rd_strobe, 0);
    txq.push_back(16'hB001); txq.push_back(16'hB002);
    cyc(15);
    chk("R4", "refill consumed", txq.size(), 0);
    dev_req = 1'b0;
    wait_idle();
    chk("R4", "bus_oe idle", bus_oe, 0);

    // zero counts, receive FIFO of two words
    rxq.delete();
    rx_cap = 2;
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    cyc(1);
    dev_req = 1'b1;
    cyc(30);
    chk("R7", "rx fill stops at cap", rxq.size(), 2);
    chk("R7", "strobe held off on full", rd_strobe, 0);
    chk("R7", "ack held while full", host_ack, 1);
    drain = 1'b1;
    k = 0; while (!rd_strobe && k < 50) begin @(negedge clk); k++; end
    h = 0; while (rd_strobe && h < 50) begin h++; @(negedge clk); end
    l = 0; while (!rd_strobe && l < 50) begin l++; @(negedge clk); end
    chk("R8", "zero active width", h, 1);
    chk("R8", "zero-count period", h + l, 2);
    dev_req = 1'b0;
    wait_idle();
    drain = 1'b0;
    rx_cap = 64;
    rxq.delete();

    // one-clock request: closing phase runs, no acknowledge
    set_cfg(0, 5, 1, 1, 1, 3, 1);
    dev_req = 1'b1;
    cyc(1);
    dev_req = 1'b0;
    cnt = 0; seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (dma_busy) cnt++;
      if (host_ack) seen++;
      @(negedge clk);
    end
    chk("R6", "busy clocks setup+close", cnt, 8);
    chk("R6", "ack never raised", seen, 0);

    // direction latched at burst start
    set_cfg(0, 1, 1, 1, 4, 1, 1);
    dev_req = 1'b1;
    cyc(5);
    cfg_write = 1'b1;
    cnt = 0; seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (wr_strobe) cnt++;
      if (rd_strobe) seen++;
      @(negedge clk);
    end
    chk("R9", "wr_strobe after dir flip", cnt, 0);
    chk("R9", "reads continue", (seen > 0) ? 1 : 0, 1);
    dev_req = 1'b0;
    cfg_write = 1'b0;
    wait_idle();
    chk("R10", "busy low at end", dma_busy, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule